// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is one channel of a general-purpose timer: a 16-bit timer stage and an 8-bit prescale stage that together form a single 24-bit count. The channel runs once or repeatedly and counts either up or down. It can raise an interrupt when the count reaches the terminal value (timeout) and when the count equals a programmed compare value (match). In repeating mode it can also take a snapshot of the count at every timeout.

The two stages change roles with the direction. When the channel counts down, the prescale stage holds the low 8 bits of the 24-bit count and the timer stage holds bits 23:8. When it counts up, the prescale stage holds bits 23:16 and the timer stage holds bits 15:0. Every 24-bit quantity (interval, preload, compare, live value, snapshot) is presented to software as a timer field in bits 15:0 and a prescale field in bits 23:16. The block assembles and splits these fields with the bit ordering of the current direction, so software uses the same layout in both directions.

A plain write port and a combinational read port give access to the registers. The word addresses are 0 control, 1 interval, 2 value, 3 compare, 4 snapshot, 5 raw status, 6 mask, 7 masked status and 8 clear. Control bits 1:0 hold the mode: 1 is one-shot, 2 is repeating, and 0 or 3 means the channel does not count. Control bit 2 selects up-counting, bit 3 enables snapshots and bit 4 enables counting. In every status, mask and clear word, bit 0 is the timeout event and bit 1 is the match event.

Top module: `ptimer_chan`

## Requirements
- R1: When counting down, the value read at address 2 shows count bits 7:0 in bits 23:16 and count bits 23:8 in bits 15:0. For example, a count of 0x0000FF reads as 0x00FF0000.
- R2: When counting up, the value read at address 2 shows count bits 15:0 in bits 15:0 and count bits 23:16 in bits 23:16. A carry out of the timer field increments the prescale field.
- R3: The match event (status bit 1) is raised when the live 24-bit count equals the compare value. The compare value is built from address 3 with the same direction-dependent ordering as the count.
- R4: A write to address 2 changes the live count one cycle later, and no counting takes place in that cycle.
- R5: In repeating mode the timeout event (status bit 0) is raised at the terminal count. A down-count reloads the interval value after reaching 0. An up-count wraps to 0 after reaching the interval value.
- R6: In one-shot mode the count stops at the first timeout and holds there. No later timeout occurs until control or value is written again.
- R7: In repeating mode with control bit 3 set, each timeout copies the count at that moment into the snapshot register (address 4), while address 2 continues to show the running count.
- R8: The snapshot register keeps its value while the mode is anything other than repeating.
- R9: The masked status (address 7) equals raw status AND mask. The interrupt output is high exactly when some masked status bit is set.
- R10: Writing 1s to address 8 clears the matching raw status bits. If an event of the same kind occurs in the same cycle, the bit stays set.
- R11: While control bit 4 is 0, the count holds its value and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| irq | output | 1 | Interrupt, OR of the masked status bits |

## Verification
The checks that run on every cycle cover the following. The count must stay frozen while counting is off. A repeating timeout must be followed by a reload to the interval value, or by a wrap to zero when counting up. A one-shot timeout must not repeat. The snapshot must stay untouched outside repeating mode. A status bit must stay set after an event, even when a clear arrives in the same cycle, and status must stay quiet while counting is off. Only the bench's scenarios can show the following. The direction-dependent packing of the prescale and timer fields must appear correctly at the read port. The one-cycle delay of a preload must be visible there. The snapshot must hold the right count. The compare must fire on the combined value. The interrupt must follow the mask for each status bit.

// File: rtl/ptm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the prescaled timer channel: register word
// addresses, mode encoding, event bit positions and control bit positions.
package ptm_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_INTV  = 4'd1,
        A_VALUE = 4'd2,
        A_MATCH = 4'd3,
        A_SNAP  = 4'd4,
        A_RIS   = 4'd5,
        A_IMR   = 4'd6,
        A_MIS   = 4'd7,
        A_ICR   = 4'd8
    } ptm_addr_e;

    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_ONESHOT  = 2'd1,
        M_PERIODIC = 2'd2,
        M_RSVD     = 2'd3
    } ptm_mode_e;

    localparam int EV_TIMEOUT = 0;
    localparam int EV_MATCH   = 1;
    localparam int NUM_EV     = 2;

    localparam int CB_UP   = 2;
    localparam int CB_SNAP = 3;
    localparam int CB_EN   = 4;

endpackage

// File: rtl/ptm_regs.sv
`timescale 1ns/1ps
// Register file of the timer channel.
// Stores control, interval, compare and mask; latches a value preload for
// one cycle; assembles the 24-bit internal quantities from the software
// timer/prescale fields using the current count direction; and splits the
// live and captured counts back into that field layout for reads.
// Assumes DATA_W > TMR_W + PRE_W and that at most one write arrives per cycle.
module ptm_regs
    import ptm_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [TMR_W+PRE_W-1:0] cnt_i,
    input  logic [TMR_W+PRE_W-1:0] snap_i,
    input  logic [NUM_EV-1:0]   ris_i,
    input  logic [NUM_EV-1:0]   mis_i,
    output logic                en_o,
    output logic [1:0]          mode_o,
    output logic                up_o,
    output logic                snap_en_o,
    output logic                cfg_wr_o,
    output logic [TMR_W+PRE_W-1:0] ival_o,
    output logic [TMR_W+PRE_W-1:0] mval_o,
    output logic [NUM_EV-1:0]   imr_o,
    output logic [NUM_EV-1:0]   clr_o,
    output logic                pend_o,
    output logic [TMR_W+PRE_W-1:0] pval_o
);

    localparam int CNT_W = TMR_W + PRE_W;

    logic [1:0]        mode_q;
    logic              up_q, snen_q, en_q;
    logic [TMR_W-1:0]  it_q, mt_q;
    logic [PRE_W-1:0]  ip_q, mp_q;
    logic [NUM_EV-1:0] imr_q;
    logic              pend_q;
    logic [CNT_W-1:0]  pval_q;

    wire unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    // Build a 24-bit count from its timer and prescale fields for a direction.
    function automatic logic [CNT_W-1:0] join_f(input logic up,
                                                input logic [TMR_W-1:0] t,
                                                input logic [PRE_W-1:0] p);
        return up ? {p, t} : {t, p};
    endfunction

    // Split a 24-bit count into the software layout {prescale, timer}.
    function automatic logic [DATA_W-1:0] split_f(input logic up,
                                                  input logic [CNT_W-1:0] c);
        if (up)
            return DATA_W'(c);
        return DATA_W'({c[PRE_W-1:0], c[CNT_W-1:PRE_W]});
    endfunction

    // Register writes; the preload strobe lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
            up_q   <= 1'b0;
            snen_q <= 1'b0;
            en_q   <= 1'b0;
            it_q   <= '0;
            ip_q   <= '0;
            mt_q   <= '0;
            mp_q   <= '0;
            imr_q  <= '0;
            pend_q <= 1'b0;
            pval_q <= '0;
        end else begin
            pend_q <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL: begin
                        mode_q <= wr_data[1:0];
                        up_q   <= wr_data[CB_UP];
                        snen_q <= wr_data[CB_SNAP];
                        en_q   <= wr_data[CB_EN];
                    end
                    A_INTV: begin
                        it_q <= wr_data[TMR_W-1:0];
                        ip_q <= wr_data[TMR_W +: PRE_W];
                    end
                    A_VALUE: begin
                        pend_q <= 1'b1;
                        pval_q <= join_f(up_q, wr_data[TMR_W-1:0],
                                         wr_data[TMR_W +: PRE_W]);
                    end
                    A_MATCH: begin
                        mt_q <= wr_data[TMR_W-1:0];
                        mp_q <= wr_data[TMR_W +: PRE_W];
                    end
                    A_IMR:   imr_q <= wr_data[NUM_EV-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Decoded strobes and assembled values for the counter and status logic.
    always_comb begin
        cfg_wr_o  = wr_en && (wr_addr == A_CTRL);
        clr_o     = (wr_en && (wr_addr == A_ICR)) ? wr_data[NUM_EV-1:0] : '0;
        en_o      = en_q;
        mode_o    = mode_q;
        up_o      = up_q;
        snap_en_o = snen_q;
        imr_o     = imr_q;
        pend_o    = pend_q;
        pval_o    = pval_q;
        ival_o    = join_f(up_q, it_q, ip_q);
        mval_o    = join_f(up_q, mt_q, mp_q);
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = DATA_W'({en_q, snen_q, up_q, mode_q});
            A_INTV:  rd_data = DATA_W'({ip_q, it_q});
            A_VALUE: rd_data = split_f(up_q, cnt_i);
            A_MATCH: rd_data = DATA_W'({mp_q, mt_q});
            A_SNAP:  rd_data = split_f(up_q, snap_i);
            A_RIS:   rd_data = DATA_W'(ris_i);
            A_IMR:   rd_data = DATA_W'(imr_q);
            A_MIS:   rd_data = DATA_W'(mis_i);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ptm_counter.sv
`timescale 1ns/1ps
// Counting core of the timer channel.
// Holds the combined 24-bit count in one register. It counts up or down,
// reloads or wraps in repeating mode and halts after the first timeout in
// one-shot mode. It flags timeout and match events and captures the count
// at repeating timeouts. Assumes interval and compare arrive already
// assembled in the current direction's bit order.
module ptm_counter
    import ptm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             up_i,
    input  logic             snap_en_i,
    input  logic             cfg_wr_i,
    input  logic [CNT_W-1:0] ival_i,
    input  logic [CNT_W-1:0] mval_i,
    input  logic             pend_i,
    input  logic [CNT_W-1:0] pval_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] snap_o,
    output logic             tmo_o,
    output logic             mat_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d, snap_q;
    logic             done_q;
    logic             active, term;

    // Decide whether the counter advances this cycle and what it hits.
    always_comb begin
        active = en_i && !done_q && !pend_i &&
                 (mode_i == M_ONESHOT || mode_i == M_PERIODIC);
        term   = up_i ? (cnt_q == ival_i) : (cnt_q == '0);
        tmo_o  = active && term;
        mat_o  = active && (cnt_q == mval_i);
    end

    // Next count: preload first, then terminal handling, then a step.
    always_comb begin
        cnt_d = cnt_q;
        if (pend_i) begin
            cnt_d = pval_i;
        end else if (active) begin
            if (term) begin
                if (mode_i == M_PERIODIC)
                    cnt_d = up_i ? '0 : ival_i;
            end else begin
                cnt_d = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
            end
        end
    end

    // Count, one-shot halt flag and snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            snap_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (cfg_wr_i || pend_i)
                done_q <= 1'b0;
            else if (tmo_o && mode_i == M_ONESHOT)
                done_q <= 1'b1;
            if (tmo_o && mode_i == M_PERIODIC && snap_en_i)
                snap_q <= cnt_q;
        end
    end

    assign cnt_o  = cnt_q;
    assign snap_o = snap_q;

    // R11
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !pend_i) |=> $stable(cnt_q));

    // R5
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_o && !up_i && mode_i == M_PERIODIC) |=> (cnt_q == $past(ival_i)));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_o && up_i && mode_i == M_PERIODIC) |=> (cnt_q == '0));

    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_o && mode_i == M_ONESHOT && !cfg_wr_i) |=> !tmo_o);

    // R8
    oneshot_no_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != M_PERIODIC) |=> $stable(snap_q));

endmodule

// File: rtl/ptm_irq.sv
`timescale 1ns/1ps
// Interrupt status of the timer channel.
// One sticky raw status bit per event. In the same cycle, a new event
// outweighs a clear. The masked status and the interrupt line are derived
// combinationally. Assumes events only fire while counting is enabled.
module ptm_irq #(
    parameter int NEV = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [NEV-1:0] ev_i,
    input  logic [NEV-1:0] clr_i,
    input  logic [NEV-1:0] imr_i,
    output logic [NEV-1:0] ris_o,
    output logic [NEV-1:0] mis_o,
    output logic           irq_o
);

    logic [NEV-1:0] ris_q;

    for (genvar k = 0; k < NEV; k++) begin : g_bit
        // Sticky status bit k: set by its event, dropped by its clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ris_q[k] <= 1'b0;
            else if (ev_i[k])
                ris_q[k] <= 1'b1;
            else if (clr_i[k])
                ris_q[k] <= 1'b0;
        end

        // R10
        event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[k] |=> ris_q[k]);

        // R10
        clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !ev_i[k]) |=> !ris_q[k]);
    end

    // Masked view and the interrupt line.
    always_comb begin
        mis_o = ris_q & imr_i;
        irq_o = |mis_o;
        ris_o = ris_q;
    end

    // R11
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && clr_i == '0) |=> $stable(ris_q));

endmodule

// File: rtl/ptimer_chan.sv
`timescale 1ns/1ps
// Top of the prescaled timer channel: joins the register file, counting
// core and interrupt status. Assumes a single clock and synchronous
// active-low reset; reads are combinational.
module ptimer_chan
    import ptm_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int CNT_W = TMR_W + PRE_W;

    logic              en, up, snap_en, cfg_wr, pend, tmo, mat;
    logic [1:0]        mode;
    logic [CNT_W-1:0]  ival, mval, pval, cnt, snap;
    logic [NUM_EV-1:0] imr, clr, ris, mis, ev;

    assign ev = {mat, tmo};

    ptm_regs #(
        .TMR_W (TMR_W),
        .PRE_W (PRE_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cnt_i    (cnt),
        .snap_i   (snap),
        .ris_i    (ris),
        .mis_i    (mis),
        .en_o     (en),
        .mode_o   (mode),
        .up_o     (up),
        .snap_en_o(snap_en),
        .cfg_wr_o (cfg_wr),
        .ival_o   (ival),
        .mval_o   (mval),
        .imr_o    (imr),
        .clr_o    (clr),
        .pend_o   (pend),
        .pval_o   (pval)
    );

    ptm_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .mode_i   (mode),
        .up_i     (up),
        .snap_en_i(snap_en),
        .cfg_wr_i (cfg_wr),
        .ival_i   (ival),
        .mval_i   (mval),
        .pend_i   (pend),
        .pval_i   (pval),
        .cnt_o    (cnt),
        .snap_o   (snap),
        .tmo_o    (tmo),
        .mat_o    (mat)
    );

    ptm_irq #(
        .NEV(NUM_EV)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .en_i (en),
        .ev_i (ev),
        .clr_i(clr),
        .imr_i(imr),
        .ris_o(ris),
        .mis_o(mis),
        .irq_o(irq)
    );

endmodule

// File: tb/ptimer_chan_bench.sv
`timescale 1ns/1ps
module ptimer_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    ptimer_chan u_ptimer_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    // Reference state derived from the requirements.
    logic [1:0]  m_mode = 0, m_imr = 0, m_ris = 0;
    logic        m_up = 0, m_snen = 0, m_en = 0, m_done = 0, m_pend = 0;
    logic [15:0] m_it = 0, m_mt = 0;
    logic [7:0]  m_ip = 0, m_mp = 0;
    logic [23:0] m_pval = 0, m_cnt = 0, m_snap = 0;

    function automatic logic [23:0] jn(input logic up, input logic [15:0] t,
                                       input logic [7:0] p);
        return up ? {p, t} : {t, p};
    endfunction

    function automatic logic [31:0] sp(input logic up, input logic [23:0] c);
        return up ? {8'd0, c} : {8'd0, c[7:0], c[23:8]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Advance the reference by one clock edge with the given write.
    task automatic model_edge(input logic we, input logic [3:0] a,
                              input logic [31:0] d);
        logic [23:0] ival, mval, ncnt, nsnap;
        logic act, term, tmo, mat, ndone;
        logic [1:0] clr;
        ival = jn(m_up, m_it, m_ip);
        mval = jn(m_up, m_mt, m_mp);
        act  = m_en && !m_done && !m_pend && (m_mode == 2'd1 || m_mode == 2'd2);
        term = m_up ? (m_cnt == ival) : (m_cnt == 24'd0);
        tmo  = act && term;
        mat  = act && (m_cnt == mval);
        if (m_pend)        ncnt = m_pval;
        else if (!act)     ncnt = m_cnt;
        else if (tmo)      ncnt = (m_mode == 2'd2) ? (m_up ? 24'd0 : ival) : m_cnt;
        else               ncnt = m_up ? m_cnt + 24'd1 : m_cnt - 24'd1;
        if ((we && a == 4'd0) || m_pend) ndone = 1'b0;
        else if (tmo && m_mode == 2'd1)  ndone = 1'b1;
        else                             ndone = m_done;
        nsnap = (tmo && m_mode == 2'd2 && m_snen) ? m_cnt : m_snap;
        clr = (we && a == 4'd8) ? d[1:0] : 2'b00;
        m_ris  = (m_ris & ~clr) | {mat, tmo};
        m_cnt  = ncnt;
        m_done = ndone;
        m_snap = nsnap;
        m_pend = we && (a == 4'd2);
        if (we) begin
            case (a)
                4'd0: begin m_mode = d[1:0]; m_up = d[2]; m_snen = d[3]; m_en = d[4]; end
                4'd1: begin m_it = d[15:0]; m_ip = d[23:16]; end
                4'd2: m_pval = jn(m_up, d[15:0], d[23:16]);
                4'd3: begin m_mt = d[15:0]; m_mp = d[23:16]; end
                4'd6: m_imr = d[1:0];
                default: ;
            endcase
        end
    endtask

    // One clock cycle with an optional write; returns at the falling edge.
    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_edge(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Compare every observable against the reference.
    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(4'd2, v); chk({tag, " value"}, v, sp(m_up, m_cnt));
        rd(4'd5, v); chk({tag, " ris"}, v, {30'd0, m_ris});
        rd(4'd7, v); chk({tag, " mis"}, v, {30'd0, m_ris & m_imr});
        rd(4'd4, v); chk({tag, " snap"}, v, sp(m_up, m_snap));
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_ris & m_imr)});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(4'd2, v); chk("reset value", v, 32'd0);
        rd(4'd5, v); chk("reset ris", v, 32'd0);
        chk("reset irq", {31'd0, irq}, 32'd0);

        // R4: preload appears one cycle after the write
        cyc(1, 4'd0, 32'h02);
        cyc(1, 4'd2, 32'h0056_1234);
        rd(4'd2, v); chk("R4 before", v, 32'd0);
        run(1);
        rd(4'd2, v); chk("R4 after", v, 32'h0056_1234);

        // R1: down count, prescale holds low bits
        cyc(1, 4'd1, 32'h0005_0001);
        cyc(1, 4'd2, 32'h0005_0001);
        cyc(1, 4'd0, 32'h12);
        run(6);
        rd(4'd2, v); chk("R1 layout", v, 32'h00FF_0000);
        check_all("R1");

        // R2: up count, carry from timer field into prescale field
        cyc(1, 4'd0, 32'h06);
        cyc(1, 4'd1, 32'h0001_FFFF);
        cyc(1, 4'd2, 32'h0000_FFFE);
        cyc(1, 4'd0, 32'h16);
        run(2);
        rd(4'd2, v); chk("R2 carry", v, 32'h0001_0000);

        // R5: down repeating reload to the interval after reaching zero
        cyc(1, 4'd0, 32'h02);
        cyc(1, 4'd8, 32'h3);
        cyc(1, 4'd1, 32'h0003_0000);
        cyc(1, 4'd2, 32'h0003_0000);
        cyc(1, 4'd0, 32'h12);
        run(4);
        rd(4'd2, v); chk("R5 reload", v, 32'h0003_0000);
        rd(4'd5, v); chk("R5 timeout", v & 32'h1, 32'h1);

        // R3: match on combined count
        cyc(1, 4'd3, 32'h0002_0000);
        cyc(1, 4'd8, 32'h3);
        run(4);
        rd(4'd5, v); chk("R3 match", v & 32'h2, 32'h2);
        check_all("R3");

        // R7: repeating up count with snapshot at each timeout
        cyc(1, 4'd0, 32'h0E);
        cyc(1, 4'd1, 32'h0000_000A);
        cyc(1, 4'd2, 32'h0);
        cyc(1, 4'd0, 32'h1E);
        run(15);
        rd(4'd4, v); chk("R7 snap", v, 32'h0000_000A);
        rd(4'd2, v); chk("R7 running", v, sp(m_up, m_cnt));

        // R8 and R6: one-shot up count, snapshot untouched, count halts
        cyc(1, 4'd0, 32'h0D);
        cyc(1, 4'd1, 32'h0000_0014);
        cyc(1, 4'd2, 32'h0);
        cyc(1, 4'd8, 32'h3);
        cyc(1, 4'd0, 32'h1D);
        run(25);
        rd(4'd4, v); chk("R8 snap kept", v, 32'h0000_000A);
        rd(4'd2, v); chk("R6 halted", v, 32'h0000_0014);
        rd(4'd5, v); chk("R6 timeout", v, 32'h1);
        cyc(1, 4'd8, 32'h1);
        run(5);
        rd(4'd5, v); chk("R6 no repeat", v, 32'h0);
        rd(4'd2, v); chk("R6 still held", v, 32'h0000_0014);

        // R9: mask gating of the interrupt
        cyc(1, 4'd0, 32'h0D);
        cyc(1, 4'd2, 32'h0);
        cyc(1, 4'd0, 32'h1D);
        run(25);
        cyc(1, 4'd6, 32'h0);
        chk("R9 masked off", {31'd0, irq}, 32'd0);
        cyc(1, 4'd6, 32'h2);
        rd(4'd7, v); chk("R9 mis other", v, 32'h0);
        chk("R9 irq other", {31'd0, irq}, 32'd0);
        cyc(1, 4'd6, 32'h1);
        rd(4'd7, v); chk("R9 mis", v, 32'h1);
        chk("R9 irq", {31'd0, irq}, 32'd1);

        // R10: clear written every cycle while timeouts keep arriving
        cyc(1, 4'd0, 32'h02);
        cyc(1, 4'd1, 32'h0001_0000);
        cyc(1, 4'd2, 32'h0001_0000);
        cyc(1, 4'd0, 32'h12);
        for (int i = 0; i < 8; i++) begin
            cyc(1, 4'd8, 32'h3);
            rd(4'd5, v); chk("R10 clear vs event", v, {30'd0, m_ris});
        end

        // R11: disabled channel holds count and stays quiet
        cyc(1, 4'd0, 32'h02);
        cyc(1, 4'd8, 32'h3);
        rd(4'd2, held);
        run(10);
        rd(4'd2, v); chk("R11 hold", v, held);
        rd(4'd5, v); chk("R11 quiet", v, 32'h0);

        // Random rounds, checked against the reference.
        for (int r = 0; r < 24; r++) begin
            logic up, sn;
            logic [1:0] md;
            logic [15:0] t, mt;
            logic [7:0] p, mp;
            up = $urandom % 2;
            sn = $urandom % 2;
            md = 2'(1 + ($urandom % 2));
            if (up) begin
                t = 16'($urandom % 40); p = 8'd0;
                mt = 16'($urandom % 40); mp = 8'd0;
            end else begin
                t = 16'($urandom % 4); p = 8'($urandom);
                mt = 16'($urandom % 4); mp = 8'($urandom);
            end
            cyc(1, 4'd0, {27'd0, 1'b0, sn, up, md});
            cyc(1, 4'd1, {8'd0, p, t});
            cyc(1, 4'd3, {8'd0, mp, mt});
            cyc(1, 4'd6, 32'($urandom % 4));
            cyc(1, 4'd2, up ? 32'd0 : {8'd0, p, t});
            cyc(1, 4'd0, {27'd0, 1'b1, sn, up, md});
            for (int i = 0; i < 150; i++) begin
                if ($urandom % 16 == 0) cyc(1, 4'd8, 32'($urandom % 4));
                else                     cyc(0, 4'd0, 32'd0);
                if (i % 10 == 9) check_all("R5 random");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule